// File: doc/BRIEF.md
# Cascaded Sixteen-Line Interrupt Controller

The block gathers sixteen interrupt request lines into one interrupt to a processor. Inside are two identical eight-line controllers. The primary controller owns lines 0 to 7 and the secondary controller owns lines 8 to 15. Each controller has two byte-wide registers: a command register and a data register. Software uses them to give the controller a vector base, to mask lines one by one, to end the current interrupt, and to choose which status byte a command-register read returns.

A rising edge on a request line latches a request bit. This happens even while the line is masked. When the processor has interrupts enabled and no interrupt is being serviced, the block raises a pending flag. With the flag it presents the vector of the lowest-numbered unmasked request. The processor accepts the interrupt with a one-cycle acknowledge. On that acknowledge the request bit moves to the in-service register, and the block records which line is active. Only one line in the whole block can be in service at a time. No further interrupt is offered until software ends the active one with an end-of-interrupt command written to the controller that owns it.

Top module: `dual_irq_ctrl`

## Requirements
- R1: After reset, both data-register reads return 0xFF (all lines masked), a command-register read returns 0x00, and no interrupt is pending.
- R2: A low-to-high transition on a request input sets that line's request bit. A line held high sets its bit only once, and it sets the bit again only after it has gone low and risen again.
- R3: Writing 0x0A to a command register makes later command-register reads of that controller return its request bits. Writing 0x0B makes them return its in-service bits. Reads of the data register return the mask. The request bits are selected after reset.
- R4: A command byte with bit 4 set starts initialisation. The next data write is the vector base, and only bits 7:3 of it are kept. After that, one more data write is consumed if bit 1 of the command byte was clear, and one more if bit 0 was set. Only then do data writes load the mask. The mask does not change during initialisation.
- R5: The vector of line n of a controller equals that controller's kept base bits 7:3 followed by n in bits 2:0.
- R6: A set mask bit i keeps line i from being offered to the processor. The line's request bit is still latched while it is masked, and the line is offered once its mask bit is cleared.
- R7: Among the unmasked requests of both controllers, the lowest-numbered line wins. Lines 0 to 7 therefore beat lines 8 to 15.
- R8: An interrupt is pending only while the interrupt-enable input is high and no line is in service. On an acknowledge, the winning line's request bit is cleared and its in-service bit is set, and the pending flag drops in the next cycle. At most one in-service bit is set across both controllers.
- R9: Any command byte from 0x20 to 0x27 written to the controller that owns the active line clears that line's in-service bit and leaves no line active. Written to the other controller, it has no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| irq_in | input | 16 | Request lines; bit n is line n |
| int_enable | input | 1 | Processor interrupt-enable flag |
| bus_we | input | 1 | Register write strobe |
| bus_unit | input | 1 | 0 selects the primary controller, 1 the secondary |
| bus_port | input | 1 | 0 selects the command register, 1 the data register |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Read data for the selected register (combinational) |
| int_ack | input | 1 | Processor accepts the pending interrupt |
| int_pending | output | 1 | An interrupt is offered |
| int_vector | output | 8 | Vector of the offered interrupt, 0 when none is offered |

## Verification
Several properties are checked on every cycle. At most one in-service bit is set. The active-line record always points at a set in-service bit. The pending flag drops in the cycle after an acknowledge. The mask stays frozen while an initialisation sequence is open. Other behaviours can only be shown by the bench scenarios: which line wins when several requests arrive at once, the vector arithmetic with a truncated base, how many data words a given initialisation byte consumes, that a masked request is remembered, that a held level does not set its request bit again, and that an end-of-interrupt sent to the wrong controller is ignored. The scoreboard compares each expected vector against what the processor side sees at the moment it acknowledges.

// File: rtl/irqc_pkg.sv
package irqc_pkg;

  typedef enum logic [0:0] {
    VIEW_REQ = 1'b0,
    VIEW_SVC = 1'b1
  } status_view_e;

  localparam logic [7:0] CMD_VIEW_REQ = 8'h0A;
  localparam logic [7:0] CMD_VIEW_SVC = 8'h0B;

  localparam int INIT_START_BIT = 4;
  localparam int INIT_SOLO_BIT  = 1;
  localparam int INIT_FOURTH_BIT = 0;

  function automatic logic is_end_cmd(input logic [7:0] b);
    return b[7:3] == 5'b00100;
  endfunction

endpackage

// File: rtl/irqc_prio.sv
module irqc_prio #(
  parameter int N = 16,
  localparam int IDX_W = $clog2(N)
) (
  input  logic [N-1:0]     req,
  output logic             any,
  output logic [IDX_W-1:0] idx
);

  always_comb begin
    any = |req;
    idx = '0;
    for (int i = N - 1; i >= 0; i--) begin
      if (req[i]) idx = IDX_W'(i);
    end
  end

endmodule

// File: rtl/irqc_bank.sv
module irqc_bank
  import irqc_pkg::*;
#(
  parameter int W = 8,
  localparam int IDX_W = $clog2(W),
  localparam int BASE_W = 8 - IDX_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [W-1:0]      irq_in,
  input  logic              cmd_we,
  input  logic              data_we,
  input  logic [7:0]        wdata,
  input  logic [W-1:0]      take_oh,
  input  logic [W-1:0]      svc_clr_oh,
  output logic [W-1:0]      eligible,
  output logic [BASE_W-1:0] base,
  output logic              end_cmd,
  output logic [W-1:0]      svc,
  output logic [7:0]        cmd_rdata,
  output logic [7:0]        data_rdata
);

  logic [W-1:0]      irq_prev_q, irq_prev_d;
  logic [W-1:0]      req_q, req_d;
  logic [W-1:0]      svc_q, svc_d;
  logic [W-1:0]      mask_q, mask_d;
  logic [BASE_W-1:0] base_q, base_d;
  status_view_e      view_q, view_d;
  logic [1:0]        init_left_q, init_left_d;
  logic              want_base_q, want_base_d;

  logic init_start;
  logic init_word;

  always_comb begin
    init_start = cmd_we && wdata[INIT_START_BIT];
    init_word  = data_we && (init_left_q != 2'd0);
    end_cmd    = cmd_we && is_end_cmd(wdata);

    irq_prev_d = irq_in;
    req_d      = (req_q & ~take_oh) | (irq_in & ~irq_prev_q);
    svc_d      = (svc_q | take_oh) & ~svc_clr_oh;

    view_d = view_q;
    if (cmd_we && wdata == CMD_VIEW_REQ) view_d = VIEW_REQ;
    if (cmd_we && wdata == CMD_VIEW_SVC) view_d = VIEW_SVC;

    mask_d = mask_q;
    if (data_we && init_left_q == 2'd0) mask_d = wdata[W-1:0];

    init_left_d = init_left_q;
    want_base_d = want_base_q;
    base_d      = base_q;
    if (init_start) begin
      init_left_d = 2'd1 + 2'(!wdata[INIT_SOLO_BIT]) + 2'(wdata[INIT_FOURTH_BIT]);
      want_base_d = 1'b1;
    end else if (init_word) begin
      init_left_d = init_left_q - 2'd1;
      want_base_d = 1'b0;
      if (want_base_q) base_d = wdata[7:IDX_W];
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      irq_prev_q  <= '0;
      req_q       <= '0;
      svc_q       <= '0;
      mask_q      <= '1;
      base_q      <= '0;
      view_q      <= VIEW_REQ;
      init_left_q <= 2'd0;
      want_base_q <= 1'b0;
    end else begin
      irq_prev_q  <= irq_prev_d;
      req_q       <= req_d;
      svc_q       <= svc_d;
      mask_q      <= mask_d;
      base_q      <= base_d;
      view_q      <= view_d;
      init_left_q <= init_left_d;
      want_base_q <= want_base_d;
    end
  end

  assign eligible   = req_q & ~mask_q;
  assign base       = base_q;
  assign svc        = svc_q;
  assign cmd_rdata  = (view_q == VIEW_SVC) ? 8'(svc_q) : 8'(req_q);
  assign data_rdata = 8'(mask_q);

  assert_mask_frozen_init_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (init_left_q != 2'd0) |=> $stable(mask_q));

  assert_svc_needs_take_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (svc_q == '0 && take_oh == '0) |=> (svc_q == '0));

endmodule

// File: rtl/dual_irq_ctrl.sv
module dual_irq_ctrl
  import irqc_pkg::*;
#(
  parameter int UNIT_LINES = 8,
  localparam int UNITS  = 2,
  localparam int TOTAL  = UNITS * UNIT_LINES,
  localparam int IDX_W  = $clog2(TOTAL),
  localparam int UIDX   = $clog2(UNIT_LINES),
  localparam int BASE_W = 8 - UIDX,
  localparam int ACT_W  = IDX_W + 1
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [TOTAL-1:0] irq_in,
  input  logic             int_enable,
  input  logic             bus_we,
  input  logic             bus_unit,
  input  logic             bus_port,
  input  logic [7:0]       bus_wdata,
  output logic [7:0]       bus_rdata,
  input  logic             int_ack,
  output logic             int_pending,
  output logic [7:0]       int_vector
);

  localparam logic [ACT_W-1:0] NONE = '1;

  logic rst_meta_q, rst_sync_q;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rst_meta_q <= 1'b0;
      rst_sync_q <= 1'b0;
    end else begin
      rst_meta_q <= 1'b1;
      rst_sync_q <= rst_meta_q;
    end
  end

  logic [UNIT_LINES-1:0] elig_u [UNITS];
  logic [UNIT_LINES-1:0] svc_u  [UNITS];
  logic [BASE_W-1:0]     base_u [UNITS];
  logic [7:0]            crd_u  [UNITS];
  logic [7:0]            drd_u  [UNITS];
  logic [UNITS-1:0]      end_u;
  logic [UNITS-1:0]      end_hit;

  logic [TOTAL-1:0] elig_all, svc_all, take_all, clr_all;
  logic             win_any;
  logic [IDX_W-1:0] win_idx;
  logic             win_unit;
  logic [ACT_W-1:0] active_q, active_d;
  logic             idle, grant, end_any;
  logic             owner_unit;

  assign idle       = (active_q == NONE);
  assign owner_unit = active_q[IDX_W-1];

  for (genvar g = 0; g < UNITS; g++) begin : g_unit
    logic sel;
    assign sel = (bus_unit == 1'(g));

    irqc_bank #(.W(UNIT_LINES)) bank_i (
      .clk        (clk),
      .rst_n      (rst_sync_q),
      .irq_in     (irq_in[g*UNIT_LINES +: UNIT_LINES]),
      .cmd_we     (bus_we && sel && !bus_port),
      .data_we    (bus_we && sel && bus_port),
      .wdata      (bus_wdata),
      .take_oh    (take_all[g*UNIT_LINES +: UNIT_LINES]),
      .svc_clr_oh (clr_all[g*UNIT_LINES +: UNIT_LINES]),
      .eligible   (elig_u[g]),
      .base       (base_u[g]),
      .end_cmd    (end_u[g]),
      .svc        (svc_u[g]),
      .cmd_rdata  (crd_u[g]),
      .data_rdata (drd_u[g])
    );

    assign elig_all[g*UNIT_LINES +: UNIT_LINES] = elig_u[g];
    assign svc_all[g*UNIT_LINES +: UNIT_LINES]  = svc_u[g];
    assign end_hit[g] = end_u[g] && !idle && (owner_unit == 1'(g));
  end

  irqc_prio #(.N(TOTAL)) prio_i (
    .req (elig_all),
    .any (win_any),
    .idx (win_idx)
  );

  assign win_unit = win_idx[IDX_W-1];

  always_comb begin
    int_pending = int_enable && idle && win_any;
    grant       = int_pending && int_ack;
    end_any     = |end_hit;
    take_all    = grant ? (TOTAL'(1) << win_idx) : '0;
    clr_all     = end_any ? (TOTAL'(1) << active_q[IDX_W-1:0]) : '0;
    int_vector  = int_pending ? {base_u[win_unit], win_idx[UIDX-1:0]} : 8'h00;
    bus_rdata   = bus_port ? drd_u[bus_unit] : crd_u[bus_unit];

    active_d = active_q;
    if (grant)        active_d = {1'b0, win_idx};
    else if (end_any) active_d = NONE;
  end

  always_ff @(posedge clk or negedge rst_sync_q) begin
    if (!rst_sync_q) active_q <= NONE;
    else             active_q <= active_d;
  end

  assert_single_service_R8: assert property (@(posedge clk) disable iff (!rst_sync_q)
    $countones(svc_all) <= 1);

  assert_ack_quiets_R8: assert property (@(posedge clk) disable iff (!rst_sync_q)
    (int_pending && int_ack) |=> !int_pending);

  assert_active_in_service_R9: assert property (@(posedge clk) disable iff (!rst_sync_q)
    !idle |-> svc_all[active_q[IDX_W-1:0]]);

  assert_idle_no_service_R9: assert property (@(posedge clk) disable iff (!rst_sync_q)
    idle |-> (svc_all == '0));

endmodule

// File: tb/dual_irq_ctrl_tb.sv
module dual_irq_ctrl_tb_top;

  logic        clk = 1'b0;
  logic        rst_n;
  logic [15:0] irq_in;
  logic        int_enable;
  logic        bus_we, bus_unit, bus_port;
  logic [7:0]  bus_wdata;
  logic [7:0]  bus_rdata;
  logic        int_ack;
  logic        int_pending;
  logic [7:0]  int_vector;

  int total = 0;
  int fails = 0;
  bit done  = 0;

  logic [7:0] exp_q[$];
  string      tag_q[$];

  always #2 clk = ~clk;

  dual_irq_ctrl dut_i (
    .clk(clk), .rst_n(rst_n), .irq_in(irq_in), .int_enable(int_enable),
    .bus_we(bus_we), .bus_unit(bus_unit), .bus_port(bus_port),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .int_ack(int_ack),
    .int_pending(int_pending), .int_vector(int_vector)
  );

  task automatic chk(input string req, input int act, input int exp);
    total++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s: actual 0x%0h expected 0x%0h", req, act, exp);
    end
  endtask

  task automatic summary();
    $display("%0d/%0d checks passed", total - fails, total);
    $finish;
  endtask

  always @(negedge clk) begin
    #1;
    if (rst_n && int_ack) begin
      if (!int_pending) begin
        chk("R8 acknowledge without pending", 0, 1);
        if (exp_q.size() > 0) begin void'(exp_q.pop_front()); void'(tag_q.pop_front()); end
      end else if (exp_q.size() == 0) begin
        chk("R8 unexpected delivery", int_vector, 0);
      end else begin
        logic [7:0] e;
        string t;
        e = exp_q.pop_front();
        t = tag_q.pop_front();
        chk(t, int_vector, e);
      end
    end
  end

  task automatic wr(input logic u, input logic p, input logic [7:0] d);
    @(negedge clk);
    bus_we = 1'b1; bus_unit = u; bus_port = p; bus_wdata = d;
    @(negedge clk);
    bus_we = 1'b0;
  endtask

  task automatic rd_chk(input logic u, input logic p, input logic [7:0] exp, input string req);
    @(negedge clk);
    bus_unit = u; bus_port = p;
    #1;
    chk(req, bus_rdata, exp);
  endtask

  task automatic pend_chk(input logic exp_p, input logic [7:0] exp_v, input string req);
    @(negedge clk);
    #1;
    chk(req, int_pending, exp_p);
    if (exp_p) chk(req, int_vector, exp_v);
  endtask

  task automatic deliver(input logic [7:0] vec, input string req);
    @(negedge clk);
    exp_q.push_back(vec);
    tag_q.push_back(req);
    int_ack = 1'b1;
    @(negedge clk);
    int_ack = 1'b0;
  endtask

  task automatic raise(input int n);
    @(negedge clk);
    irq_in[n] = 1'b1;
  endtask

  initial begin
    #(200000 * 4);
    if (!done) begin
      chk("watchdog expired", 0, 1);
      summary();
    end
  end

  initial begin
    rst_n = 1'b0; irq_in = '0; int_enable = 1'b0; int_ack = 1'b0;
    bus_we = 1'b0; bus_unit = 1'b0; bus_port = 1'b0; bus_wdata = '0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);

    // R1 reset state
    rd_chk(0, 1, 8'hFF, "R1 primary mask");
    rd_chk(1, 1, 8'hFF, "R1 secondary mask");
    rd_chk(0, 0, 8'h00, "R1 primary request view");
    pend_chk(0, 0, "R1 nothing pending");

    // R4 primary: bit1 clear and bit0 set -> base, one word, one word
    wr(0, 0, 8'h11); wr(0, 1, 8'h0D); wr(0, 1, 8'h04); wr(0, 1, 8'h01);
    rd_chk(0, 1, 8'hFF, "R4 primary mask untouched by init words");
    // R4 secondary: bit1 set and bit0 set -> base and one word
    wr(1, 0, 8'h13); wr(1, 1, 8'h70); wr(1, 1, 8'h01);
    rd_chk(1, 1, 8'hFF, "R4 secondary mask untouched by init words");
    wr(0, 1, 8'h02);
    wr(1, 1, 8'h00);
    rd_chk(0, 1, 8'h02, "R3 primary data read returns mask");
    rd_chk(1, 1, 8'h00, "R3 secondary data read returns mask");
    int_enable = 1'b1;

    // R6 masked line latches but is not offered
    raise(1);
    pend_chk(0, 0, "R6 masked line not offered");
    rd_chk(0, 0, 8'h02, "R2 request bit latched on rising edge");

    // R7 simultaneous lines 3 and 9; R5 base 0x0D keeps 0x08
    @(negedge clk); irq_in[3] = 1'b1; irq_in[9] = 1'b1;
    pend_chk(1, 8'h0B, "R7 lowest line wins, R5 vector");
    deliver(8'h0B, "R7 delivered vector line 3");
    pend_chk(0, 0, "R8 pending drops after acknowledge");
    wr(0, 0, 8'h0B);
    rd_chk(0, 0, 8'h08, "R3 service view shows line 3");
    wr(0, 0, 8'h0A);
    rd_chk(0, 0, 8'h02, "R8 request bit 3 cleared on acknowledge");

    // R9 end command to the wrong controller
    wr(1, 0, 8'h20);
    pend_chk(0, 0, "R9 end to non-owner ignored");
    wr(0, 0, 8'h0B);
    rd_chk(0, 0, 8'h08, "R9 service bit kept after non-owner end");

    // R9 end to owner, then secondary line 9 is offered
    wr(0, 0, 8'h25);
    rd_chk(0, 0, 8'h00, "R9 owner end clears service bit");
    pend_chk(1, 8'h71, "R7 secondary line offered after end");
    deliver(8'h71, "R5 secondary vector line 9");
    wr(1, 0, 8'h0B);
    rd_chk(1, 0, 8'h02, "R8 secondary service bit set");

    // R8 enable gating
    int_enable = 1'b0;
    raise(0);
    wr(1, 0, 8'h20);
    pend_chk(0, 0, "R8 no offer while enable low");
    @(negedge clk); int_enable = 1'b1;
    pend_chk(1, 8'h08, "R8 offer once enable high");
    deliver(8'h08, "R8 delivered line 0");
    wr(0, 0, 8'h20);
    pend_chk(0, 0, "R2 held level does not set again");

    // R6 unmask a remembered request
    wr(0, 1, 8'h00);
    pend_chk(1, 8'h09, "R6 remembered request offered after unmask");
    deliver(8'h09, "R6 delivered line 1");
    wr(0, 0, 8'h27);
    pend_chk(0, 0, "R9 end 0x27 frees");

    // R2 new edge after a low phase
    @(negedge clk); irq_in[3] = 1'b0;
    @(negedge clk); irq_in[3] = 1'b1;
    pend_chk(1, 8'h0B, "R2 re-raised line offered");
    deliver(8'h0B, "R2 delivered line 3 again");
    wr(0, 0, 8'h20);
    rd_chk(0, 0, 8'h00, "R9 service clear after final end");

    repeat (3) @(negedge clk);
    chk("R8 all expected deliveries seen", exp_q.size(), 0);
    done = 1;
    summary();
  end

endmodule